// File: doc/BRIEF.md
# Serial Control Register Port for a Dual-Channel Converter

This block is a serial slave that gives a host read and write access to five 8-bit control registers for a two-channel converter. A transfer opens when chip select goes low. The host first shifts in an instruction word, which carries a direction flag, a byte count and a start address. Then it shifts one to four data bytes in or out. The serial pins are synchronised into the system clock domain. Input bits are taken on the rising edge of the serial clock. Read bits are launched on its falling edge. A separate output enable lets the data-out line share a wire with data-in for a 3-wire hookup.

Register 0 sets how the port itself behaves. One bit picks the bit order, one bit picks a short or long address field, and one bit is a software reset. That reset returns every other register to its default and holds it there until the host writes the bit back to zero. Register 0 also holds a regulator-off control and a read-only regulator status bit. The other registers drive the converter's power, data-format, clocking, gain and reference-resistor controls through plain output ports.

The serial pins carry no valid/ready stream, and none of the ports uses handshaking or back-pressure. Every control and status pin is a plain level.

Top module: `spi_cfg_port`

## Requirements
- R1: After the hardware reset (`rst_n` low), registers 0 to 4 read back 0x00, 0x00, 0x16, 0x00 and 0x00. `fmt_ctl` is 7'h16 and `core_rst` is 0.
- R2: In short mode the instruction has 8 bits. Bit 7 is the direction (1 = read). Bits 6:5 hold N, and the transfer moves N+1 data bytes. Bits 4:0 hold the address.
- R3: When register 0 bit 2 is 1, the instruction has 16 bits. Bit 15 is the direction, bits 14:13 are the count and bits 12:0 are the address. The bit-order and address-mode bits are sampled while chip select is high, so a change takes effect from the next transfer.
- R4: When register 0 bit 0 is 1, every instruction and data word is shifted bit 0 first. When it is 0, the top bit goes first.
- R5: After each data byte the address steps by one. It counts down in MSB-first order and up in LSB-first order.
- R6: A read returns the last value written for each writable bit, and 0 for every bit that cannot be written. Register 0 bit 4 reads the `ldo_on` input.
- R7: A write to any address outside 0 to 4 changes no register. A read from such an address returns 0x00.
- R8: While register 0 bit 1 is 1, `core_rst` is high. Registers 1 to 4 are held at their defaults and writes to them are ignored. Register 0 keeps its value and stays writable. The reset ends only when a later write clears bit 1.
- R9: The output ports map the register fields as follows:
  - `ldo_off` is reg0[3].
  - `pwr_ctl[5:0]` is reg1[5:0]: power-down, I-out off, Q-out off, I-clock off, Q-clock off and external reference.
  - `fmt_ctl[6:0]` is reg2[6:0]: two's complement, I first, I on the falling edge, simultaneous-enable block, clock-in enable, clock-out enable and double-strength clock-out.
  - `gain_code` is reg3[5:0].
  - `rset_code` is reg4[5:0].
  - `rset_en` is reg4[7].
- R10: `spi_sdo` changes only after a falling edge of the serial clock. `spi_sdo_oe` is high only in the data phase of a read, from its first falling edge until chip select rises.
- R11: Raising chip select at any point ends the transfer. The next transfer starts again with an instruction.
- R12: A data byte is written on its 8th rising edge. A byte cut short by chip select is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock |
| spi_csn | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial data out |
| spi_sdo_oe | output | 1 | Drive enable for serial data out |
| ldo_on | input | 1 | Regulator status, 1 = on |
| core_rst | output | 1 | Software reset to the converter core |
| ldo_off | output | 1 | Regulator-off control |
| pwr_ctl | output | 6 | Power and clock gating controls |
| fmt_ctl | output | 7 | Data format and data-clock controls |
| gain_code | output | 6 | Fine gain code for the I channel |
| rset_code | output | 6 | Reference resistor code |
| rset_en | output | 1 | Reference resistor enable |

## Verification
The assertions assume that the serial clock is slow compared with `clk`. Each level must last at least four system clocks, so every edge is seen once after the two-stage synchroniser, and data-in must be stable across the rising edge. They also assume chip select stays high for several system clocks between transfers, so the bit-order and address-mode settings are sampled cleanly. The stimulus holds each serial clock level for eight system clocks. It changes data-in only while the serial clock is low, and it keeps chip select high for twelve system clocks between transfers, including after a deliberately aborted one.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 13;
  localparam int SHORT_AW = 5;
  localparam int NUM_REGS = 5;
  localparam int IW_LONG  = 16;
  localparam int IW_SHORT = 8;

  // register 0 bit positions
  localparam int B0_LSB  = 0;
  localparam int B0_SRST = 1;
  localparam int B0_LONG = 2;
  localparam int B0_LDO  = 3;
  localparam int B0_STAT = 4;

  typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;

  function automatic logic [7:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'h0F;
      1:       return 8'h3F;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'hBF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 2) ? 8'h16 : 8'h00;
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= (s == 0) ? din : stg[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi_s,
  input  logic              cfg_lsb,
  input  logic              cfg_long,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  phase_t              phase;
  logic [3:0]          bitcnt;
  logic [IW_LONG-1:0]  sh, sh_nx, word;
  logic                lsb_q, long_q, rw_q;
  logic [1:0]          left_q;
  logic [ADDR_W-1:0]   addr_q, addr_step, dec_addr;
  logic [7:0]          tx, byte_nx;
  logic [3:0]          ilast;
  logic                dec_rw;
  logic [1:0]          dec_cnt;

  always_comb begin
    sh_nx     = lsb_q ? {sdi_s, sh[IW_LONG-1:1]} : {sh[IW_LONG-2:0], sdi_s};
    ilast     = long_q ? 4'(IW_LONG - 1) : 4'(IW_SHORT - 1);
    if (long_q)     word = sh_nx;
    else if (lsb_q) word = {8'h00, sh_nx[15:8]};
    else            word = {8'h00, sh_nx[7:0]};
    dec_rw    = long_q ? word[15] : word[7];
    dec_cnt   = long_q ? word[14:13] : word[6:5];
    dec_addr  = long_q ? word[ADDR_W-1:0] : {{(ADDR_W-SHORT_AW){1'b0}}, word[SHORT_AW-1:0]};
    byte_nx   = lsb_q ? sh_nx[15:8] : sh_nx[7:0];
    addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    rd_addr   = (phase == PH_INSTR) ? dec_addr : addr_step;
  end

  assign wr_en   = !csn_s && rise && (phase == PH_DATA) && (bitcnt == 4'd7) && !rw_q;
  assign wr_addr = addr_q;
  assign wr_data = byte_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_INSTR;
      bitcnt <= '0;
      sh     <= '0;
      lsb_q  <= 1'b0;
      long_q <= 1'b0;
      rw_q   <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
      tx     <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (csn_s) begin
      phase  <= PH_INSTR;
      bitcnt <= '0;
      lsb_q  <= cfg_lsb;
      long_q <= cfg_long;
      sdo_oe <= 1'b0;
    end else if (rise) begin
      sh <= sh_nx;
      case (phase)
        PH_INSTR: begin
          if (bitcnt == ilast) begin
            rw_q   <= dec_rw;
            left_q <= dec_cnt;
            addr_q <= dec_addr;
            phase  <= PH_DATA;
            bitcnt <= '0;
            if (dec_rw) tx <= rd_data;
          end else bitcnt <= bitcnt + 1'b1;
        end
        PH_DATA: begin
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            addr_q <= addr_step;
            if (left_q == 2'd0) phase <= PH_DONE;
            else                left_q <= left_q - 1'b1;
            if (rw_q) tx <= rd_data;
          end else bitcnt <= bitcnt + 1'b1;
        end
        default: ;
      endcase
    end else if (fall && phase == PH_DATA && rw_q) begin
      sdo    <= lsb_q ? tx[0] : tx[7];
      tx     <= lsb_q ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
      sdo_oe <= 1'b1;
    end
  end

  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (phase == PH_INSTR && bitcnt == 4'd0)); // R11
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo)); // R10
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !csn_s) |-> rw_q); // R10
  AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R12
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              ldo_on,
  output logic              cfg_lsb,
  output logic              cfg_long,
  output logic              core_rst,
  output logic              ldo_off,
  output logic [5:0]        pwr_ctl,
  output logic [6:0]        fmt_ctl,
  output logic [5:0]        gain_code,
  output logic [5:0]        rset_code,
  output logic              rset_en
);
  logic [7:0] regs [NUM_REGS];
  logic       srst;

  assign srst = regs[0][B0_SRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reg_default(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (i != 0 && srst)
          regs[i] <= reg_default(i);
        else if (wr_en && wr_addr == ADDR_W'(i))
          regs[i] <= wr_data & reg_mask(i);
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    if (rd_addr == '0) rd_data[B0_STAT] = ldo_on;
  end

  assign cfg_lsb   = regs[0][B0_LSB];
  assign cfg_long  = regs[0][B0_LONG];
  assign core_rst  = srst;
  assign ldo_off   = regs[0][B0_LDO];
  assign pwr_ctl   = regs[1][5:0];
  assign fmt_ctl   = regs[2][6:0];
  assign gain_code = regs[3][5:0];
  assign rset_code = regs[4][5:0];
  assign rset_en   = regs[4][7];

  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (regs[1] == 8'h00 && regs[2] == 8'h16 && regs[3] == 8'h00 && regs[4] == 8'h00)); // R8
  AST_UNDEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= ADDR_W'(NUM_REGS)) |=> ($stable(regs[0]) && $stable(regs[1]) &&
      $stable(regs[2]) && $stable(regs[3]) && $stable(regs[4]))); // R7
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sclk,
  input  logic       spi_csn,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic       spi_sdo_oe,
  input  logic       ldo_on,
  output logic       core_rst,
  output logic       ldo_off,
  output logic [5:0] pwr_ctl,
  output logic [6:0] fmt_ctl,
  output logic [5:0] gain_code,
  output logic [5:0] rset_code,
  output logic       rset_en
);
  logic [2:0]        pins_s;
  logic              sclk_s, csn_s, sdi_s, sclk_d;
  logic              rise, fall;
  logic              cfg_lsb, cfg_long, wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  spi_cfg_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({spi_sdi, spi_csn, spi_sclk}), .dout(pins_s));

  assign sclk_s = pins_s[0];
  assign csn_s  = pins_s[1];
  assign sdi_s  = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  spi_cfg_engine u_engine (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .rise(rise), .fall(fall),
    .sdi_s(sdi_s), .cfg_lsb(cfg_lsb), .cfg_long(cfg_long), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(spi_sdo), .sdo_oe(spi_sdo_oe));

  spi_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ldo_on(ldo_on),
    .cfg_lsb(cfg_lsb), .cfg_long(cfg_long), .core_rst(core_rst), .ldo_off(ldo_off),
    .pwr_ctl(pwr_ctl), .fmt_ctl(fmt_ctl), .gain_code(gain_code),
    .rset_code(rset_code), .rset_en(rset_en));
endmodule

// File: tb/spi_cfg_port_test.sv
module spi_cfg_port_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, ldo_on = 1'b0;
  logic sdo, sdo_oe, core_rst, ldo_off, rset_en;
  logic [5:0] pwr_ctl, gain_code, rset_code;
  logic [6:0] fmt_ctl;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .ldo_on(ldo_on), .core_rst(core_rst),
    .ldo_off(ldo_off), .pwr_ctl(pwr_ctl), .fmt_ctl(fmt_ctl), .gain_code(gain_code),
    .rset_code(rset_code), .rset_en(rset_en));

  // address, write data, expected readback (short mode, MSB first)
  localparam logic [23:0] VEC [10] = '{
    {8'h01, 8'hFF, 8'h3F}, {8'h02, 8'hFF, 8'h7F}, {8'h03, 8'hAB, 8'h2B},
    {8'h04, 8'hFF, 8'hBF}, {8'h07, 8'h55, 8'h00}, {8'h1F, 8'hAA, 8'h00},
    {8'h02, 8'h16, 8'h16}, {8'h01, 8'h00, 8'h00}, {8'h04, 8'h00, 8'h00},
    {8'h03, 8'h00, 8'h00}};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic rb, output logic oe);
    sdi = b;
    repeat (HALF) @(negedge clk);
    rb = sdo;
    oe = sdo_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic spi_xfer(input bit rd, input int nb, input logic [12:0] a, input bit lsb,
                          input bit lng, input logic [31:0] wd, output logic [31:0] rdat,
                          output int oe_cnt);
    logic [15:0] ins;
    logic b, oe;
    int ilen;
    ins  = lng ? {rd, 2'(nb - 1), a} : {8'h00, rd, 2'(nb - 1), a[4:0]};
    ilen = lng ? 16 : 8;
    rdat = '0;
    oe_cnt = 0;
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < ilen; i++) begin
      int k = lsb ? i : ilen - 1 - i;
      spi_bit(ins[k], b, oe);
    end
    for (int by = 0; by < nb; by++) begin
      for (int i = 0; i < 8; i++) begin
        int k = lsb ? i : 7 - i;
        spi_bit(wd[8*by+k], b, oe);
        rdat[8*by+k] = b;
        if (oe) oe_cnt++;
      end
    end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input bit lsb, input bit lng);
    logic [31:0] r;
    int oc;
    spi_xfer(1'b0, 1, a, lsb, lng, {24'h0, d}, r, oc);
    chk(oc == 0, "R10 oe low in write", 32'(oc), 0);
  endtask

  task automatic rd(input logic [12:0] a, input bit lsb, input bit lng, output logic [7:0] d);
    logic [31:0] r;
    int oc;
    spi_xfer(1'b1, 1, a, lsb, lng, 32'h0, r, oc);
    d = r[7:0];
    chk(oc == 8, "R10 oe high in read", 32'(oc), 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] r;
    int oc;
    logic b, oe;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(fmt_ctl == 7'h16, "R1 fmt_ctl", 32'(fmt_ctl), 32'h16);
    chk(core_rst == 1'b0, "R1 core_rst", 32'(core_rst), 0);
    chk(sdo_oe == 1'b0, "R10 oe idle", 32'(sdo_oe), 0);
    for (int i = 0; i < 5; i++) begin
      rd(13'(i), 1'b0, 1'b0, d);
      chk(d == ((i == 2) ? 8'h16 : 8'h00), "R1 reset readback", 32'(d), (i == 2) ? 32'h16 : 0);
    end

    // R2 R6 R7 R9 vector walk
    for (int v = 0; v < 10; v++) begin
      logic [7:0] a, wdv, ev;
      {a, wdv, ev} = VEC[v];
      wr(13'(a), wdv, 1'b0, 1'b0);
      rd(13'(a), 1'b0, 1'b0, d);
      chk(d == ev, "R2/R6/R7 readback", 32'(d), 32'(ev));
      case (a)
        8'h01: chk(pwr_ctl == ev[5:0], "R9 pwr_ctl", 32'(pwr_ctl), 32'(ev[5:0]));
        8'h02: chk(fmt_ctl == ev[6:0], "R9 fmt_ctl", 32'(fmt_ctl), 32'(ev[6:0]));
        8'h03: chk(gain_code == ev[5:0], "R9 gain_code", 32'(gain_code), 32'(ev[5:0]));
        8'h04: chk({rset_en, rset_code} == {ev[7], ev[5:0]}, "R9 rset", 32'({rset_en, rset_code}),
                   32'({ev[7], ev[5:0]}));
        default: ;
      endcase
    end

    // R5 multi-byte MSB first: address counts down
    spi_xfer(1'b0, 2, 13'd3, 1'b0, 1'b0, 32'h0000_052A, r, oc);
    spi_xfer(1'b1, 2, 13'd3, 1'b0, 1'b0, 32'h0, r, oc);
    chk(r[15:0] == 16'h052A, "R5 MSB down-count", r, 32'h052A);
    chk(oc == 16, "R10 oe two bytes", 32'(oc), 16);

    // R4 R5 LSB first: address counts up
    wr(13'd0, 8'h01, 1'b0, 1'b0);
    spi_xfer(1'b0, 3, 13'd1, 1'b1, 1'b0, 32'h0007_1221, r, oc);
    chk(pwr_ctl == 6'h21, "R4 LSB write", 32'(pwr_ctl), 32'h21);
    spi_xfer(1'b1, 3, 13'd1, 1'b1, 1'b0, 32'h0, r, oc);
    chk(r[23:0] == 24'h07_1221, "R5 LSB up-count", r, 32'h071221);
    wr(13'd0, 8'h00, 1'b1, 1'b0);
    rd(13'd0, 1'b0, 1'b0, d);
    chk(d == 8'h00, "R4 back to MSB", 32'(d), 0);

    // R3 long address mode
    wr(13'd0, 8'h04, 1'b0, 1'b0);
    wr(13'd4, 8'h85, 1'b0, 1'b1);
    rd(13'd4, 1'b0, 1'b1, d);
    chk(d == 8'h85, "R3 long readback", 32'(d), 32'h85);
    chk(rset_en == 1'b1 && rset_code == 6'h05, "R9 rset long", 32'({rset_en, rset_code}), 32'h45);
    wr(13'h1004, 8'h3F, 1'b0, 1'b1);
    rd(13'd4, 1'b0, 1'b1, d);
    chk(d == 8'h85, "R7 high address write ignored", 32'(d), 32'h85);
    rd(13'h1004, 1'b0, 1'b1, d);
    chk(d == 8'h00, "R7 high address reads zero", 32'(d), 0);
    wr(13'd0, 8'h00, 1'b0, 1'b1);
    rd(13'd0, 1'b0, 1'b0, d);
    chk(d == 8'h00, "R3 back to short", 32'(d), 0);

    // R8 software reset
    wr(13'd1, 8'h3F, 1'b0, 1'b0);
    wr(13'd0, 8'h0A, 1'b0, 1'b0);
    chk(core_rst == 1'b1, "R8 core_rst set", 32'(core_rst), 1);
    chk(ldo_off == 1'b1, "R9 ldo_off", 32'(ldo_off), 1);
    chk(pwr_ctl == 6'h00 && rset_en == 1'b0, "R8 defaults", 32'(pwr_ctl), 0);
    wr(13'd1, 8'h3F, 1'b0, 1'b0);
    rd(13'd1, 1'b0, 1'b0, d);
    chk(d == 8'h00, "R8 write held off", 32'(d), 0);
    rd(13'd0, 1'b0, 1'b0, d);
    chk(d == 8'h0A, "R8 reg0 kept", 32'(d), 32'h0A);
    wr(13'd0, 8'h00, 1'b0, 1'b0);
    chk(core_rst == 1'b0, "R8 released", 32'(core_rst), 0);
    wr(13'd1, 8'h15, 1'b0, 1'b0);
    chk(pwr_ctl == 6'h15, "R8 writable again", 32'(pwr_ctl), 32'h15);

    // R6 status bit
    ldo_on = 1'b1;
    repeat (4) @(negedge clk);
    rd(13'd0, 1'b0, 1'b0, d);
    chk(d == 8'h10, "R6 ldo status", 32'(d), 32'h10);
    wr(13'd0, 8'h00, 1'b0, 1'b0);
    rd(13'd0, 1'b0, 1'b0, d);
    chk(d == 8'h10, "R6 status not writable", 32'(d), 32'h10);

    // R11 R12 abort in the middle of a data byte
    csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] ins = 8'h03;
      spi_bit(ins[i], b, oe);
    end
    for (int i = 0; i < 4; i++) spi_bit(1'b1, b, oe);
    csn = 1'b1;
    repeat (12) @(negedge clk);
    chk(gain_code == 6'h00, "R12 partial byte dropped", 32'(gain_code), 0);
    wr(13'd3, 8'h11, 1'b0, 1'b0);
    chk(gain_code == 6'h11, "R11 next transfer clean", 32'(gain_code), 32'h11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule